// File: doc/BRIEF.md
# Write-Protected Reset Control Register

This block is a single 32-bit register on a simple bus. Each of its functional bits drives the reset of one target. The register decodes its own address. Writes reach it only while an external write-protect unlock input is high. Reads are answered at all times. The unlock key sequence that raises that input belongs to a neighbouring lock block and is not built here.

Three bits are level-held resets: writing 1 keeps the target in reset until software writes 0. Two bits are self-clearing one-shots. Writing 1 to either of them asserts the matching reset output for a fixed number of cycles, two by default. The bit then returns to 0 without software action. One one-shot resets the processor core together with the flash memory controller. The other resets the whole chip. Every output comes straight from a flop, so it changes in the cycle after the accepted write. The register is cleared only by the system reset input, never by the resets it issues.

Top module: `prot_rst_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every reset output goes low and a read at the register offset returns 0x0000_0000.
- R2: The register answers only at offset 0x08. A write to any other address changes nothing, and a read at any other address returns 0.
- R3: Bit 7 drives `crc_rst`, bit 4 drives `div_rst` and bit 2 drives `dma_rst`. An accepted write loads each of these bits from the written data. The output follows in the next cycle and holds until another accepted write changes it.
- R4: Bit 1 drives `core_rst`. An accepted write with bit 1 set raises it in the next cycle for exactly PULSE_CYCLES cycles (default 2). After that it clears by itself.
- R5: Bit 0 drives `chip_rst` with the same one-shot timing as R4.
- R6: A write made while `lock_open` is low is ignored: no output and no read-back bit changes.
- R7: Bits 31:8, 6:5 and 3 always read as 0. Writing 1 to them has no effect on any output.
- R8: An accepted write of 1 to a one-shot bit while its pulse is running restarts the full PULSE_CYCLES count.
- R9: An accepted write of 0 to a one-shot bit while its pulse is running does not shorten the pulse.
- R10: Reads are answered whatever the state of `lock_open`. The read-back of bits 1 and 0 shows 1 exactly while the matching pulse output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 32 | Read data, combinational from address and register |
| lock_open | input | 1 | High while the write-protect lock is open |
| crc_rst | output | 1 | Level-held reset to the CRC unit |
| div_rst | output | 1 | Level-held reset to the hardware divider |
| dma_rst | output | 1 | Level-held reset to the DMA controller |
| core_rst | output | 1 | One-shot reset to the core and flash controller |
| chip_rst | output | 1 | One-shot whole-chip reset |

## Verification
Two events can fall in the same cycle: a one-shot pulse counting down, and a new accepted write to the same bit. A write of 1 restarts the count. A write of 0 must leave the count alone. The bench provokes both by issuing the second write one cycle after the first, while the pulse is half done. It judges the result by how many consecutive sampled cycles the pulse output stays high: PULSE_CYCLES+1 for a restart, PULSE_CYCLES for a write of 0. It also sweeps all 256 low-byte patterns twice, once with the lock closed and once with it open, and compares outputs and read-back against a model of the held bits.

// File: rtl/prc_pkg.sv
// Package: shared constants for the protected reset control register.
// Assumes a 32-bit data path. The bit positions below are decoded by
// neighbouring software, so they are fixed rather than free parameters.
package prc_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned HELD_N   = 3;
    localparam int unsigned PULSE_N  = 2;
    // level-held targets: CRC unit, hardware divider, DMA controller
    localparam int unsigned HELD_POS  [HELD_N]  = '{7, 4, 2};
    // one-shot targets: core plus flash controller, whole chip
    localparam int unsigned PULSE_POS [PULSE_N] = '{1, 0};
endpackage

// File: rtl/prc_access.sv
// Module: prc_access
// Decodes the register address and gates writes with the write-protect
// unlock. Assumes one access per cycle and a combinational read path.
module prc_access #(
    parameter int unsigned            ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]      REG_OFFSET = 8'h08
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              lock_open,
    output logic              hit,
    output logic              wr_ok
);
    // address match and protected write qualification
    always_comb begin
        hit   = (addr == REG_OFFSET);
        wr_ok = hit && we && lock_open;
    end
endmodule

// File: rtl/prc_held_bit.sv
// Module: prc_held_bit
// One level-held reset bit. It loads from write data on an accepted write
// and keeps its value otherwise. Assumes wr_ok is already qualified.
module prc_held_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic d,
    output logic q
);
    // register the held reset level
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_ok) q <= d;
    end

    // R3: the level changes only on an accepted write
    assert_held_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(q));
    // R3: an accepted write lands in the flop
    assert_held_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (q == $past(d)));
endmodule

// File: rtl/prc_pulse_bit.sv
// Module: prc_pulse_bit
// Self-clearing one-shot reset bit. A set loads a countdown of PULSE_CYCLES.
// The output flop is high while the count is non-zero. Assumes set is
// already qualified by address, write strobe, unlock and a data bit of 1.
module prc_pulse_bit #(
    parameter int unsigned PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic q
);
    localparam int unsigned    CW   = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0]  LOAD = CW'(PULSE_CYCLES);
    localparam logic [CW-1:0]  ONE  = CW'(1);

    logic [CW-1:0] cnt;

    // countdown: reload on set (also restarts a running pulse), else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (set)          cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - ONE;
    end

    // registered output: high from set until the count expires
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (set)  q <= 1'b1;
        else           q <= (cnt > ONE);
    end

    // R4/R5: a set loads the full count
    assert_pulse_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (cnt == LOAD));
    // R8/R9: without a set the count only steps down
    assert_pulse_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && cnt != '0) |=> (cnt == $past(cnt) - ONE));
    // R5: the output flop tracks the live countdown
    assert_pulse_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q == (cnt != '0));
endmodule

// File: rtl/prot_rst_ctl.sv
// Module: prot_rst_ctl
// Write-protected reset control register: three level-held resets and two
// self-clearing one-shot resets behind a simple bus. Assumes lock_open comes
// from a separate lock block and that the register clears only on rst_n.
module prot_rst_ctl
    import prc_pkg::*;
#(
    parameter int unsigned        ADDR_W       = 8,
    parameter logic [ADDR_W-1:0]  REG_OFFSET   = 8'h08,
    parameter int unsigned        PULSE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_open,
    output logic              crc_rst,
    output logic              div_rst,
    output logic              dma_rst,
    output logic              core_rst,
    output logic              chip_rst
);
    logic               hit;
    logic               wr_ok;
    logic [HELD_N-1:0]  held_q;
    logic [PULSE_N-1:0] pulse_q;
    logic [DATA_W-1:0]  view;
    logic               unused_wdata;

    // reserved data bits are accepted on the bus but never stored
    assign unused_wdata = ^bus_wdata;

    prc_access #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_access (
        .addr      (bus_addr),
        .we        (bus_we),
        .lock_open (lock_open),
        .hit       (hit),
        .wr_ok     (wr_ok)
    );

    for (genvar gi = 0; gi < HELD_N; gi++) begin : g_held
        prc_held_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_ok (wr_ok),
            .d     (bus_wdata[HELD_POS[gi]]),
            .q     (held_q[gi])
        );
    end

    for (genvar gp = 0; gp < PULSE_N; gp++) begin : g_pulse
        prc_pulse_bit #(
            .PULSE_CYCLES (PULSE_CYCLES)
        ) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (wr_ok && bus_wdata[PULSE_POS[gp]]),
            .q     (pulse_q[gp])
        );
    end

    // assemble the register image; unlisted positions stay zero
    always_comb begin
        view = '0;
        for (int i = 0; i < int'(HELD_N); i++)  view[HELD_POS[i]]  = held_q[i];
        for (int j = 0; j < int'(PULSE_N); j++) view[PULSE_POS[j]] = pulse_q[j];
    end

    // read mux: image at the register offset, zero elsewhere
    always_comb begin
        bus_rdata = hit ? view : '0;
    end

    // drive the named reset outputs from their flops
    always_comb begin
        crc_rst  = held_q[0];
        div_rst  = held_q[1];
        dma_rst  = held_q[2];
        core_rst = pulse_q[0];
        chip_rst = pulse_q[1];
    end

    // R6: a write with the lock closed leaves the register image unchanged
    assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !lock_open) |=> $stable(view) || $fell(core_rst) || $fell(chip_rst));
    // R2: a write elsewhere does not touch the held bits
    assert_offset_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != REG_OFFSET) |=> $stable(held_q));
    // R7: reserved positions read as zero
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~32'h0000_0097) == '0);
    // R1: the register image is clear in the cycle after a reset edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (view == '0));
endmodule

// File: tb/test_prot_rst_ctl.sv
// Bench for prot_rst_ctl: reset check, a full sweep of the low byte with the
// lock closed and open, then restart and write-0 collisions on the one-shots.
module test_prot_rst_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        lock_open = 1'b0;
    logic        crc_rst, div_rst, dma_rst, core_rst, chip_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic m_crc = 1'b0, m_div = 1'b0, m_dma = 1'b0;

    always #2.5 clk = ~clk;

    prot_rst_ctl i_prot_rst_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .lock_open (lock_open),
        .crc_rst   (crc_rst),
        .div_rst   (div_rst),
        .dma_rst   (dma_rst),
        .core_rst  (core_rst),
        .chip_rst  (chip_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic lk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; lock_open = lk;
        step();
        bus_we = 1'b0; lock_open = 1'b0; bus_addr = 8'h08;
    endtask

    function automatic logic [31:0] image(logic c1, logic c0);
        return {24'h0, m_crc, 2'b00, m_div, 1'b0, m_dma, c1, c0};
    endfunction

    task automatic chk_outs(input string req, input logic c1, input logic c0);
        chk({req, " held"}, {29'h0, crc_rst, div_rst, dma_rst}, {29'h0, m_crc, m_div, m_dma});
        chk({req, " pulses"}, {30'h0, core_rst, chip_rst}, {30'h0, c1, c0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bus_addr = 8'h08;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_outs("R1", 1'b0, 1'b0);
        chk("R1 readback", bus_rdata, 32'h0);
        rst_n = 1'b1;
        step();

        // R2: foreign offset is neither written nor read
        wr(8'h0C, 32'hFFFF_FFFF, 1'b1);
        chk_outs("R2", 1'b0, 1'b0);
        bus_addr = 8'h0C;
        #0.1 chk("R2 foreign read", bus_rdata, 32'h0);
        bus_addr = 8'h08;
        step(); step();

        for (int v = 0; v < 256; v++) begin
            logic [31:0] d;
            d = {8'(v * 37 + 11), 8'(v ^ 8'h5A), 8'(255 - v), 8'(v)};
            // R6: locked write is ignored
            wr(8'h08, d, 1'b0);
            chk_outs("R6", 1'b0, 1'b0);
            chk("R6 readback", bus_rdata, image(1'b0, 1'b0));
            // R3/R4/R5/R7: unlocked write
            m_crc = d[7]; m_div = d[4]; m_dma = d[2];
            wr(8'h08, d, 1'b1);
            chk_outs("R3 R4 R5 cycle1", d[1], d[0]);
            chk("R7 R10 readback", bus_rdata, image(d[1], d[0]));
            step();
            chk_outs("R4 R5 cycle2", d[1], d[0]);
            step();
            chk_outs("R4 R5 expired", 1'b0, 1'b0);
            chk("R10 readback expired", bus_rdata, image(1'b0, 1'b0));
        end

        // R8: restart the core pulse one cycle into its run
        m_crc = 1'b0; m_div = 1'b0; m_dma = 1'b0;
        wr(8'h08, 32'h0000_0002, 1'b1);
        chk_outs("R8 start", 1'b1, 1'b0);
        wr(8'h08, 32'h0000_0003, 1'b1);
        chk_outs("R8 restart", 1'b1, 1'b1);
        step();
        chk_outs("R8 extended", 1'b1, 1'b1);
        step();
        chk_outs("R8 end", 1'b0, 1'b0);

        // R9: a write of 0 mid-pulse does not cut it short
        wr(8'h08, 32'h0000_0001, 1'b1);
        chk_outs("R9 start", 1'b0, 1'b1);
        m_dma = 1'b1;
        wr(8'h08, 32'h0000_0004, 1'b1);
        chk_outs("R9 kept", 1'b0, 1'b1);
        step();
        chk_outs("R9 end", 1'b0, 1'b0);

        // R10: reads answered with lock closed while held bits are set
        lock_open = 1'b0;
        #0.1 chk("R10 locked read", bus_rdata, image(1'b0, 1'b0));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule